// File: doc/BRIEF.md
# Dual-CPU Boot Source Selector

This block decides, once per reset, where each of two processors fetches its first instructions. On the first clock edge after reset release it captures the two boot-mode pins and the two per-CPU lock option bits. From then on it presents a boot-source code for CPU1, a boot-source code for CPU2, a hold request that keeps CPU1 stopped, and a write-protect flag for the stored CPU2 boot vector and CPU2 option fields. The captured values do not change until the next reset.

The CPU1 lock pins CPU1 to user flash whatever the pins request, and it cancels the CPU2 install/service pin mode. A software remap selection stays live after capture and can still redirect CPU1 with or without the lock. The CPU2 lock replaces the CPU2 install/service entry with the stored secure boot vector. It also write-protects the vector and option fields, and it leaves CPU1's pin-selected source untouched.

Source codes, used on both source outputs and on the remap selector: 0 user flash, 1 system flash / bootloader, 2 SRAM1, 3 CPU2 secure boot vector.

Top module: `boot_src_sel`

## Requirements
- R1: Between reset release and the first clock edge that follows it, `c1_src_o` = 0, `c2_src_o` = 3, `c1_hold_o` = 1 and `c2_vec_wp_o` = 0. The remap inputs are ignored during this window.
- R2: Pins and lock bits are captured only on the first rising clock edge after reset release. Later changes on `boot_pins_i`, `c1_lock_i` and `c2_lock_i` do not affect any output until the next reset.
- R3: With the CPU1 lock clear and remap disabled, pin code 0 gives `c1_src_o` = 0, pin code 1 gives 1 and pin code 2 gives 2. Pin code 3 selects the CPU2 boot mode, with `c1_src_o` = 0.
- R4: With the CPU1 lock set and remap disabled, `c1_src_o` = 0 for every pin code. Pin code 3 then does not enter the CPU2 boot mode: `c1_hold_o` = 0 and `c2_src_o` = 3.
- R5: After capture, `remap_en_i` = 1 with `remap_sel_i` in {0,1,2} drives `c1_src_o` to `remap_sel_i`, whatever the lock state. `remap_sel_i` = 3 is ignored and the pin/lock-derived source is kept.
- R6: In the CPU2 boot mode with the CPU2 lock clear, `c2_src_o` = 1 (install/service entry) and `c1_hold_o` = 1.
- R7: In the CPU2 boot mode with the CPU2 lock set, `c2_src_o` = 3 (stored secure vector) and `c1_hold_o` = 1.
- R8: The CPU2 lock has no effect on `c1_src_o` for pin codes 0, 1 and 2.
- R9: After capture, `c2_vec_wp_o` equals the captured CPU2 lock bit, whatever the pin code.
- R10: After capture and outside the CPU2 boot mode, `c1_hold_o` = 0 and `c2_src_o` = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| boot_pins_i | input | 2 | Boot-mode pin code (3 = CPU2 boot mode) |
| c1_lock_i | input | 1 | CPU1 boot lock option bit |
| c2_lock_i | input | 1 | CPU2 boot lock option bit |
| remap_en_i | input | 1 | Software remap of CPU1 boot source enabled |
| remap_sel_i | input | 2 | Software-selected CPU1 source code |
| c1_src_o | output | 2 | CPU1 boot-source code |
| c2_src_o | output | 2 | CPU2 boot-source code |
| c1_hold_o | output | 1 | Keep CPU1 stopped |
| c2_vec_wp_o | output | 1 | Write-protect for CPU2 boot vector and option fields |

## Verification
A corrupted capture register is visible on the first sample after the capture edge. It shows as a wrong source code, a wrong hold, or a write-protect flag that disagrees with the lock that was applied. A capture that is not one-shot shows up only after the pins or locks are changed later, so every configuration is followed by an inverted-input phase with all outputs compared again. A bad override path shows up only in the lock and pin combinations that reach it, which is why all sixteen pin/lock combinations and every remap code are swept.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam int unsigned SRC_W = 2;
  localparam int unsigned PIN_W = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_USER = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_SRAM = 2'd2,
    SRC_SVEC = 2'd3
  } boot_src_e;

  localparam logic [PIN_W-1:0] PIN_CPU2 = 2'd3;
endpackage

// File: rtl/boot_capture.sv
module boot_capture
  import boot_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIN_W-1:0] pins_i,
  input  logic             lock1_i,
  input  logic             lock2_i,
  output logic             taken_o,
  output logic [PIN_W-1:0] pins_o,
  output logic             lock1_o,
  output logic             lock2_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o <= 1'b0;
      pins_o  <= '0;
      lock1_o <= 1'b0;
      lock2_o <= 1'b0;
    end else if (!taken_o) begin
      // one-shot capture on first edge after release
      taken_o <= 1'b1;
      pins_o  <= pins_i;
      lock1_o <= lock1_i;
      lock2_o <= lock2_i;
    end
  end
endmodule

// File: rtl/cpu1_src_sel.sv
module cpu1_src_sel
  import boot_pkg::*;
(
  input  logic             taken_i,
  input  logic [PIN_W-1:0] pins_i,
  input  logic             lock1_i,
  input  logic             remap_en_i,
  input  logic [SRC_W-1:0] remap_sel_i,
  output logic [SRC_W-1:0] src_o,
  output logic             c2_mode_o
);
  boot_src_e base;
  logic      remap_ok;

  always_comb begin
    c2_mode_o = taken_i && (pins_i == PIN_CPU2) && !lock1_i;
    if (!taken_i || lock1_i || pins_i == PIN_CPU2) base = SRC_USER;
    else                                          base = boot_src_e'(pins_i);
    remap_ok = taken_i && remap_en_i && (remap_sel_i != SRC_SVEC);
    src_o    = remap_ok ? remap_sel_i : base;
  end
endmodule

// File: rtl/cpu2_src_sel.sv
module cpu2_src_sel
  import boot_pkg::*;
(
  input  logic             taken_i,
  input  logic             c2_mode_i,
  input  logic             lock2_i,
  output logic [SRC_W-1:0] src_o,
  output logic             c1_hold_o,
  output logic             wp_o
);
  always_comb begin
    src_o     = (c2_mode_i && !lock2_i) ? SRC_SYS : SRC_SVEC;
    c1_hold_o = !taken_i || c2_mode_i;
    wp_o      = lock2_i;
  end
endmodule

// File: rtl/boot_src_sel.sv
module boot_src_sel
  import boot_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] boot_pins_i,
  input  logic       c1_lock_i,
  input  logic       c2_lock_i,
  input  logic       remap_en_i,
  input  logic [1:0] remap_sel_i,
  output logic [1:0] c1_src_o,
  output logic [1:0] c2_src_o,
  output logic       c1_hold_o,
  output logic       c2_vec_wp_o
);
  logic             taken;
  logic [PIN_W-1:0] pins_q;
  logic             lock1_q;
  logic             lock2_q;
  logic             c2_mode;

  boot_capture u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pins_i  (boot_pins_i),
    .lock1_i (c1_lock_i),
    .lock2_i (c2_lock_i),
    .taken_o (taken),
    .pins_o  (pins_q),
    .lock1_o (lock1_q),
    .lock2_o (lock2_q)
  );

  cpu1_src_sel u_c1 (
    .taken_i     (taken),
    .pins_i      (pins_q),
    .lock1_i     (lock1_q),
    .remap_en_i  (remap_en_i),
    .remap_sel_i (remap_sel_i),
    .src_o       (c1_src_o),
    .c2_mode_o   (c2_mode)
  );

  cpu2_src_sel u_c2 (
    .taken_i   (taken),
    .c2_mode_i (c2_mode),
    .lock2_i   (lock2_q),
    .src_o     (c2_src_o),
    .c1_hold_o (c1_hold_o),
    .wp_o      (c2_vec_wp_o)
  );
endmodule

// File: rtl/boot_src_sel_chk.sv
module boot_src_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       taken,
  input logic       lock1_q,
  input logic [1:0] c1_src_o,
  input logic [1:0] c2_src_o,
  input logic       c1_hold_o,
  input logic       c2_vec_wp_o
);
  AST_WP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken && $past(taken)) |-> $stable(c2_vec_wp_o)); // R2
  AST_C2SRC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken && $past(taken)) |-> $stable(c2_src_o)); // R2
  AST_RUN_NO_HOLD_SVEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken && !c1_hold_o) |-> (c2_src_o == 2'd3)); // R10
  AST_INSTALL_HOLDS_C1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c2_src_o == 2'd1) |-> c1_hold_o); // R6
  AST_LOCK1_NO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken && lock1_q) |-> !c1_hold_o); // R4
  AST_C1_NEVER_SVEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c1_src_o != 2'd3); // R5
  AST_PRECAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken |-> (c1_hold_o && c1_src_o == 2'd0 && !c2_vec_wp_o)); // R1
endmodule

bind boot_src_sel boot_src_sel_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .taken       (taken),
  .lock1_q     (lock1_q),
  .c1_src_o    (c1_src_o),
  .c2_src_o    (c2_src_o),
  .c1_hold_o   (c1_hold_o),
  .c2_vec_wp_o (c2_vec_wp_o)
);

// File: tb/tb_boot_src_sel.sv
`timescale 1ns/100ps
module tb_boot_src_sel;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] boot_pins_i = '0;
  logic       c1_lock_i = 1'b0;
  logic       c2_lock_i = 1'b0;
  logic       remap_en_i = 1'b0;
  logic [1:0] remap_sel_i = '0;
  logic [1:0] c1_src_o, c2_src_o;
  logic       c1_hold_o, c2_vec_wp_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  boot_src_sel dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected values from the source-code table
  function automatic int e_c1(int p, int l1, int re, int rs);
    int b;
    b = (l1 != 0 || p == 3) ? 0 : p;
    if (re != 0 && rs != 3) b = rs;
    return b;
  endfunction
  function automatic int e_mode(int p, int l1);
    return (p == 3 && l1 == 0) ? 1 : 0;
  endfunction
  function automatic int e_c2(int p, int l1, int l2);
    return (e_mode(p, l1) != 0 && l2 == 0) ? 1 : 3;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 4; p++)
      for (int l1 = 0; l1 < 2; l1++)
        for (int l2 = 0; l2 < 2; l2++) begin
          @(negedge clk_i);
          rst_ni = 1'b0;
          boot_pins_i = 2'(p);
          c1_lock_i = 1'(l1);
          c2_lock_i = 1'(l2);
          remap_en_i = 1'b1;
          remap_sel_i = 2'd2;
          #1 rst_ni = 1'b1;
          #0.5;
          // R1: before capture edge
          chk("R1 c1_src", c1_src_o, 0);
          chk("R1 c2_src", c2_src_o, 3);
          chk("R1 hold", c1_hold_o, 1);
          chk("R1 wp", c2_vec_wp_o, 0);
          remap_en_i = 1'b0;
          @(posedge clk_i);
          @(negedge clk_i);
          // R3 R4 R8: pin/lock decode
          chk("R3/R4/R8 c1_src", c1_src_o, e_c1(p, l1, 0, 0));
          // R6 R7 R10 R4: CPU2 mode outputs
          chk("R6/R7/R10 c2_src", c2_src_o, e_c2(p, l1, l2));
          chk("R6/R7/R10 hold", c1_hold_o, e_mode(p, l1));
          chk("R9 wp", c2_vec_wp_o, l2);
          // R5: remap live
          for (int rs = 0; rs < 4; rs++) begin
            remap_en_i = 1'b1;
            remap_sel_i = 2'(rs);
            #1;
            chk("R5 c1_src", c1_src_o, e_c1(p, l1, 1, rs));
          end
          remap_en_i = 1'b0;
          // R2: later input changes ignored
          boot_pins_i = 2'(~p);
          c1_lock_i = 1'(~l1);
          c2_lock_i = 1'(~l2);
          repeat (2) @(posedge clk_i);
          @(negedge clk_i);
          chk("R2 c1_src", c1_src_o, e_c1(p, l1, 0, 0));
          chk("R2 c2_src", c2_src_o, e_c2(p, l1, l2));
          chk("R2 hold", c1_hold_o, e_mode(p, l1));
          chk("R2 wp", c2_vec_wp_o, l2);
        end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule